// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them and raises a single interrupt line toward a processor. When the processor strobes acknowledge, the block returns an 8-bit vector. Its upper five bits come from a programmed base and its lower three bits give the winning level. Software sets the block up through a two-register interface selected by one address bit. First comes a short initialization sequence of two to four words. After that, command words set the mask, end interrupts, change the priority order and choose what a read returns.

The block keeps three 8-bit registers: pending requests, in-service levels and mask. Requests can be latched on rising edges or can follow the line levels. Priority is fixed by default, with level 0 highest. It can be rotated so that a serviced level drops to the bottom, or set directly by a command. An interrupt can be closed by a command or at acknowledge time. A special mask mode lets lower levels interrupt a handler that is still in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, and after any write with `addr0`=0 and `wdata[4]`=1 (the start word), the mask and in-service registers are all zero. Priority is fixed with level 0 highest, special mask mode and rotation are off, and reads with `addr0`=0 return the request register. Reads with `addr0`=1 always return the mask.
- R2: In the start word, bit 3=1 selects level triggering, bit 1=1 selects single mode and bit 0=1 means a final word follows. The next `addr0`=1 write is the base word. In cascade mode one more `addr0`=1 word is consumed. If bit 0 was set, the final word is consumed last. None of these words changes the mask.
- R3: The vector returned during an acknowledge with `int_out`=1 is {base word bits 7..3, winning level}.
- R4: In edge mode a request bit is set by a rising edge on its line and cleared by the acknowledge of that level. In level mode the request register follows the lines. Masked requests still appear in the request register.
- R5: Once initialization is complete, an `addr0`=1 write loads the mask. A 1 in bit n keeps line n from raising `int_out`.
- R6: `int_out` is 1 exactly when some unmasked pending level has priority above every set in-service bit.
- R7: An acknowledge sets the winner's in-service bit. If the final initialization word had bit 1=1 (automatic end), the in-service bit stays clear.
- R8: A command with `addr0`=0 and bits 4..3=00 and bits 6..5=01 clears the highest-priority set in-service bit.
- R9: A command with bits 4..3=00 and bits 6..5=11 clears the in-service bit named by bits 2..0.
- R10: In an end command, bit 7=1 makes the cleared level the lowest priority. A command with bits 7..5=110 and bits 4..3=00 makes level bits 2..0 the lowest priority.
- R11: A command with `addr0`=0 and bits 4..3=01 selects the read source from bits 1..0: 10 selects the request register, 11 selects in-service, and 00 or 01 leave the choice unchanged.
- R12: In that command, bit 2=1 makes the next `addr0`=0 read return {`int_out`, 0000, winning level}, where the winning level reads 7 when nothing is pending. Later reads return the selected register again.
- R13: In that command, bits 6..5=11 turn special mask mode on and 10 turn it off. While it is on, only the in-service bit of the same level blocks a pending request.
- R14: An acknowledge with `int_out`=0 returns {base, 111} and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr0 | input | 1 | Register select for reads and writes |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe; ends a poll read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| irq_in | input | 8 | Request lines, one per level |
| int_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector, valid while `ack` is high |

## Verification
The hardest state to reach from the ports is a rotated order in which an in-service level sits above a pending lower-numbered request. Reaching it takes a chain of steps: an edge request is acknowledged, then closed with the rotate bit set, and only then does a new edge arrive on level 0. The stimulus then acknowledges level 7 first and shows that level 0 is blocked. A set-priority command then moves level 0 back above level 7, and that release shows up on `int_out`. Special mask mode is reached in a similar way. Two levels are kept in service, and masking is used to leave pending only a level whose own in-service bit is set.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr0,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic [7:0] vec_out
);
  localparam int unsigned NLV = 8;
  localparam int unsigned LW  = $clog2(NLV);

  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} ist_t;
  ist_t ist;

  logic          lvl_trig, single, need4, aeoi, rot_en, sel_isr, smm, poll;
  logic [4:0]    base;
  logic [NLV-1:0] imr, isr, irr_q, irq_d, irr, pend;
  logic [LW-1:0] lp, win, ihi;
  logic          win_ok, ihi_ok;

  assign irr  = lvl_trig ? irq_in : irr_q;
  assign pend = irr & ~imr;

  always_comb begin
    logic [LW-1:0] idx;
    logic blk;
    win = '1; win_ok = 1'b0; ihi = '0; ihi_ok = 1'b0; blk = 1'b0;
    for (int k = 0; k < NLV; k++) begin
      idx = lp + LW'(k) + LW'(1);
      if (!win_ok && !blk) begin
        if (pend[idx] && !isr[idx]) begin
          win = idx; win_ok = 1'b1;
        end else if (isr[idx] && !smm) begin
          blk = 1'b1;
        end
      end
      if (isr[idx] && !ihi_ok) begin
        ihi = idx; ihi_ok = 1'b1;
      end
    end
  end

  assign int_out = win_ok;
  assign vec_out = {base, win};
  assign rdata   = addr0 ? imr : (poll ? {win_ok, 4'b0000, win} : (sel_isr ? isr : irr));

  wire is_run = (ist == ST_RUN);
  wire wr_c   = wr_en && !addr0;
  wire wr_d   = wr_en && addr0;
  wire icw1   = wr_c && wdata[4];
  wire ocw2   = wr_c && is_run && (wdata[4:3] == 2'b00);
  wire ocw3   = wr_c && is_run && (wdata[4:3] == 2'b01);
  wire eoi_ns = ocw2 && wdata[5] && !wdata[6];
  wire eoi_sp = ocw2 && wdata[5] && wdata[6];
  wire setp   = ocw2 && !wdata[5] && wdata[6] && wdata[7];
  wire rotcfg = ocw2 && !wdata[5] && !wdata[6];
  wire take   = ack && win_ok;
  wire clr_go = eoi_sp || (eoi_ns && ihi_ok);
  wire [LW-1:0] clr_lvl = eoi_sp ? wdata[2:0] : ihi;

  logic [NLV-1:0] isr_nx;
  logic [LW-1:0]  lp_nx;
  always_comb begin
    isr_nx = isr;
    lp_nx  = lp;
    if (clr_go) begin
      isr_nx[clr_lvl] = 1'b0;
      if (wdata[7]) lp_nx = clr_lvl;
    end
    if (setp) lp_nx = wdata[2:0];
    if (take) begin
      if (!aeoi) isr_nx[win] = 1'b1;
      else if (rot_en) lp_nx = win;
    end
  end

  wire [NLV-1:0] ack_clr = take ? (NLV'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist <= ST_RUN; lvl_trig <= 1'b0; single <= 1'b0; need4 <= 1'b0;
      aeoi <= 1'b0; rot_en <= 1'b0; sel_isr <= 1'b0; smm <= 1'b0; poll <= 1'b0;
      base <= '0; imr <= '0; isr <= '0; irr_q <= '0; irq_d <= '0; lp <= '1;
    end else begin
      irq_d <= irq_in;
      if (icw1) begin
        ist <= ST_W2; lvl_trig <= wdata[3]; single <= wdata[1]; need4 <= wdata[0];
        aeoi <= 1'b0; rot_en <= 1'b0; sel_isr <= 1'b0; smm <= 1'b0; poll <= 1'b0;
        imr <= '0; isr <= '0; irr_q <= '0; lp <= '1;
      end else begin
        irr_q <= (irr_q | (irq_in & ~irq_d)) & ~ack_clr;
        isr   <= isr_nx;
        lp    <= lp_nx;
        unique case (ist)
          ST_W2: if (wr_d) begin
            base <= wdata[7:3];
            ist  <= !single ? ST_W3 : (need4 ? ST_W4 : ST_RUN);
          end
          ST_W3: if (wr_d) ist <= need4 ? ST_W4 : ST_RUN;
          ST_W4: if (wr_d) begin
            aeoi <= wdata[1];
            ist  <= ST_RUN;
          end
          default: if (wr_d) imr <= wdata;
        endcase
        if (rotcfg) rot_en <= wdata[7];
        if (ocw3) begin
          if (wdata[1]) sel_isr <= wdata[0];
          if (wdata[6]) smm <= wdata[5];
        end
        if (ocw3 && wdata[2]) poll <= 1'b1;
        else if (rd_en && !addr0) poll <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr0,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       ack,
  input logic       int_out,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic       aeoi,
  input logic       is_run
);
  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr0 && wdata[4]) |=> (isr == 8'h00 && imr == 8'h00));
  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr0 && is_run) |=> (imr == $past(wdata)));
  // R6
  int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != 8'h00));
  // R7
  ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !wr_en) |=> (isr != 8'h00));
  // R14
  spurious_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !wr_en) |=> $stable(isr));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr0(addr0), .wr_en(wr_en), .wdata(wdata),
  .ack(ack), .int_out(int_out), .irr(irr), .imr(imr), .isr(isr),
  .aeoi(aeoi), .is_run(is_run)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr0 = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0, peek = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, vec_out;
  logic int_out;
  int nvec = 0, nbad = 0;
  int q_kind[$];
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .addr0(addr0), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .ack(ack), .vec_out(vec_out));

  always @(negedge clk) begin
    if (rd_en || ack || peek) begin
      if (q_kind.size() == 0) begin
        nbad++;
        $display("FAIL scoreboard: got result 00 expected an entry 01");
      end else begin
        int k;
        logic [7:0] e, a;
        string t;
        k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        a = (k == 0) ? rdata : (k == 1) ? vec_out : {7'b0, int_out};
        nvec++;
        if (a !== e) begin
          nbad++;
          $display("FAIL %s: got %02h expected %02h", t, a, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    tick(); addr0 = a; wdata = d; wr_en = 1'b1;
    tick(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    tick(); addr0 = a; rd_en = 1'b1;
    tick(); rd_en = 1'b0;
  endtask

  task automatic acknowledge(input logic [7:0] e, input string t);
    q_kind.push_back(1); q_exp.push_back(e); q_tag.push_back(t);
    tick(); ack = 1'b1;
    tick(); ack = 1'b0;
  endtask

  task automatic chk_int(input logic e, input string t);
    q_kind.push_back(2); q_exp.push_back({7'b0, e}); q_tag.push_back(t);
    tick(); peek = 1'b1;
    tick(); peek = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    tick(); irq_in = v;
    tick();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick(); rst_n = 1'b1;
    rd(1'b1, 8'h00, "R1 reset mask");
    rd(1'b0, 8'h00, "R1 reset request read");
    chk_int(1'b0, "R1 reset int");
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R2 init words leave mask");
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R5 mask load");
    lines(8'h88);
    rd(1'b0, 8'h88, "R4 edge request incl masked");
    chk_int(1'b1, "R6 unmasked pending");
    acknowledge(8'h43, "R3 vector base|level");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R7 R11 in-service read");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h80, "R4 ack clears request");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h80, "R11 code 00 keeps selection");
    chk_int(1'b0, "R5 masked line quiet");
    wr(1'b1, 8'h00);
    chk_int(1'b0, "R6 lower than in-service");
    lines(8'h02);
    chk_int(1'b1, "R6 higher than in-service");
    acknowledge(8'h41, "R3 level 1");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h0A, "R7 two in service");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R8 nonspecific end");
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h00, "R9 specific end");
    chk_int(1'b1, "R6 level 7 released");
    acknowledge(8'h47, "R3 level 7");
    lines(8'h06);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R12 poll code");
    rd(1'b0, 8'h80, "R12 poll one shot");
    acknowledge(8'h42, "R3 level 2");
    lines(8'h26);
    chk_int(1'b0, "R6 level 5 blocked");
    wr(1'b0, 8'h68);
    chk_int(1'b1, "R13 special mask lets lower in");
    lines(8'hA6);
    wr(1'b1, 8'h20);
    chk_int(1'b0, "R13 same level still blocks");
    wr(1'b0, 8'h48);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h20); wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R8 two ends");
    acknowledge(8'h45, "R3 level 5");
    wr(1'b0, 8'hA0);
    lines(8'hA7);
    acknowledge(8'h47, "R10 rotated order picks 7 over 0");
    chk_int(1'b0, "R10 level 0 below 7 after rotate");
    wr(1'b0, 8'hC7);
    chk_int(1'b1, "R10 set priority");
    wr(1'b0, 8'h67);
    acknowledge(8'h40, "R10 level 0 wins");
    rd(1'b0, 8'h01, "R7 level 0 in service");
    wr(1'b0, 8'h1B); wr(1'b1, 8'h80); wr(1'b1, 8'h03);
    rd(1'b0, 8'hA7, "R1 R4 level mode request read");
    wr(1'b1, 8'hFE);
    rd(1'b1, 8'hFE, "R2 single mode skips third word");
    chk_int(1'b1, "R6 level request");
    acknowledge(8'h80, "R3 new base");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R7 automatic end");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'hA7, "R4 level request stays");
    wr(1'b1, 8'hFF);
    chk_int(1'b0, "R5 all masked");
    acknowledge(8'h87, "R14 spurious vector");
    rd(1'b0, 8'hA7, "R14 request unchanged");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R14 in-service unchanged");
    tick(); tick();
    finish_run();
  end
endmodule